// File: doc/BRIEF.md
# Serial-Bus Register Access Slave for a Clock/Calendar

This block is the two-wire serial-bus slave that sits in front of a clock/calendar core. It oversamples the bus clock and data lines on the system clock and recognises START, repeated START and STOP. It decodes a 7-bit device address, takes a register pointer, and then either stores incoming bytes or returns register bytes. Each byte goes most significant bit first, and a ninth clock carries the acknowledge. It serves a 32-byte register space. Time bytes live in the external timekeeping core. Alarm bytes, the control byte, two alarm flags and sixteen scratch bytes are held locally.

Reads of the time bytes come from a snapshot buffer and not from the live counters. That way a multi-byte read never sees a rollover in the middle of the transfer. The snapshot is refreshed on every START, on every STOP, and whenever the pointer steps from 1Fh to 00h. Writes to time bytes are not held here. Each one leaves as a single-cycle strobe carrying a byte index and a value, issued at the acknowledge of that byte. The serial bus cannot be stalled by this slave, so the strobe has no back-pressure: the core must take it in the cycle it appears. Alarm, control and flag state are presented on plain output pins. The external alarm logic sets the flags through a plain input.

Top module: `rtc_i2c_regfile`

## Requirements
- R1: An address byte of D0h (write) or D1h (read), that is device address 1101000 plus the direction bit, is acknowledged with SDA held low on the ninth clock. Any other address is not acknowledged. After that, no further byte is acknowledged until a new START.
- R2: In a write, the first byte after the address sets the 5-bit register pointer. Each later byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R3: The pointer steps from 1Fh to 00h, so a write that begins at 1Fh stores its second byte at 00h.
- R4: Read bytes at 00h–06h come from a snapshot of `time_live_i`, where byte n is bits 8n+7:8n. The snapshot is refreshed on START, on STOP, and when the pointer steps to 00h. Changes to the live input in the middle of a transfer do not appear otherwise.
- R5: A read returns bytes from the current pointer, and the pointer advances after each byte. A read without a preceding pointer write continues from where the last transfer left the pointer.
- R6: When the master does not acknowledge a read byte, the slave stops driving SDA and leaves it released until the next START or STOP.
- R7: A repeated START after a pointer write begins a new address phase without a STOP, so the following read starts at that pointer.
- R8: Bytes move most significant bit first, and the slave changes its SDA drive only while SCL is low.
- R9: After reset the control byte is 98h (bit 7 clock enable = 1, bits 6:5 source select = 00, bits 4:3 rate select = 11, bit 2 interrupt mode = 0, bits 1:0 alarm enables = 00). Both flags, all alarm bytes and the scratch bytes are 00h, and SDA is released.
- R10: A byte written to 00h–06h raises `time_wr_o` for exactly one cycle, with `time_wr_idx_o` equal to the address and `time_wr_data_o` equal to the byte.
- R11: Status byte 0Fh reads as {000000, flag2, flag1}. A pulse on `alarm_set_i[n]` sets flag n+1. Writing 0 to bit n clears that flag, writing 1 leaves it unchanged, and bits 7:2 always read 0.
- R12: Bytes written to 07h–0Dh appear on `alarm_o` (address 07h+k in bits 8k+7:8k), and the byte written to 0Eh appears on `ctrl_o`. Both read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High to pull the data line low |
| time_live_i | input | 56 | Live time bytes 00h–06h from the timekeeping core |
| time_wr_o | output | 1 | One-cycle strobe for a time byte write |
| time_wr_idx_o | output | 3 | Time byte index of the strobe |
| time_wr_data_o | output | 8 | Time byte value of the strobe |
| alarm_set_i | input | 2 | Flag set pulses from the alarm logic |
| ctrl_o | output | 8 | Control byte |
| alarm_o | output | 56 | Alarm bytes 07h–0Dh |
| flags_o | output | 2 | Alarm flags |

## Verification
A level change on either bus line reaches the protocol logic as an event in the third system cycle: two synchronizer flops plus one edge register. The registered response, whether SDA drive, pointer step or snapshot request, follows one cycle later, and the snapshot copy and the local register update land one cycle after that. The time strobe appears in the same cycle as the registered write request. The bench therefore holds every SCL level for ten cycles and drives only one cycle after an edge. It samples SDA at the end of each high phase, when any drive change that began after the preceding SCL fall has long settled. The one-cycle strobes are caught by a monitor that counts them and records their index and data, and those records are checked after the STOP.

// File: rtl/rtc_i2c_pkg.sv
`timescale 1ns/1ps
package rtc_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_MACK,
    ST_IGNORE
  } bus_st_e;

  typedef enum logic [1:0] {
    AFTER_PTR,
    AFTER_WR,
    AFTER_RD
  } ack_ctx_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_cond.sv
`timescale 1ns/1ps
module i2c_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_s, sda_s;
  logic scl_p, sda_p, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[STAGES-2:0], scl_i};
      sda_s <= {sda_s[STAGES-2:0], sda_i};
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  assign scl_q     = scl_s[STAGES-1];
  assign sda_q     = sda_s[STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2c_slave_fsm.sv
`timescale 1ns/1ps
module i2c_slave_fsm
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         AW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [AW-1:0]     ptr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              snap_req
);
  bus_st_e           state;
  ack_ctx_e          ctx;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic              mack_ok;
  logic [AW-1:0]     ptr_nxt;
  logic              byte_in, rx_state;

  assign ptr_nxt  = ptr + 1'b1;
  assign byte_in  = (bitcnt == 4'd8);
  assign rx_state = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ctx      <= AFTER_PTR;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      mack_ok  <= 1'b0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      snap_req <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      snap_req <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bitcnt   <= '0;
        sda_oe   <= 1'b0;
        snap_req <= 1'b1;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        snap_req <= 1'b1;
      end else begin
        // receive side: sample on rise, decide at the fall after bit 8
        if (rx_state && scl_rise && !byte_in) begin
          shreg  <= {shreg[BYTE_W-2:0], sda_q};
          bitcnt <= bitcnt + 4'd1;
        end
        if (rx_state && scl_fall && byte_in) begin
          unique case (state)
            ST_ADDR: begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                ctx    <= shreg[0] ? AFTER_RD : AFTER_PTR;
              end else begin
                state  <= ST_IGNORE;
              end
            end
            ST_PTR: begin
              ptr    <= shreg[AW-1:0];
              sda_oe <= 1'b1;
              state  <= ST_ACK;
              ctx    <= AFTER_WR;
            end
            default: begin
              wr_en    <= 1'b1;
              wr_addr  <= ptr;
              wr_data  <= shreg;
              ptr      <= ptr_nxt;
              snap_req <= (ptr_nxt == '0);
              sda_oe   <= 1'b1;
              state    <= ST_ACK;
              ctx      <= AFTER_WR;
            end
          endcase
        end
        if (state == ST_ACK && scl_fall) begin
          bitcnt <= '0;
          unique case (ctx)
            AFTER_PTR: begin sda_oe <= 1'b0; state <= ST_PTR;   end
            AFTER_WR:  begin sda_oe <= 1'b0; state <= ST_WDATA; end
            default: begin
              txreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_RDATA;
            end
          endcase
        end
        // transmit side: shift on fall, count on rise
        if (state == ST_RDATA) begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          if (scl_fall) begin
            if (byte_in) begin
              sda_oe   <= 1'b0;
              state    <= ST_MACK;
              ptr      <= ptr_nxt;
              snap_req <= (ptr_nxt == '0);
            end else begin
              txreg  <= {txreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end
        end
        if (state == ST_MACK) begin
          if (scl_rise) mack_ok <= ~sda_q;
          if (scl_fall) begin
            if (mack_ok) begin
              txreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              bitcnt <= '0;
              state  <= ST_RDATA;
            end else begin
              state  <= ST_IGNORE;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_reg_bank.sv
`timescale 1ns/1ps
module rtc_reg_bank
  import rtc_i2c_pkg::*;
#(
  parameter int          AW         = 5,
  parameter int          TIME_REGS  = 7,
  parameter int          ALARM_REGS = 7,
  parameter logic [7:0]  CTRL_RST   = 8'h98,
  localparam int         TW         = $clog2(TIME_REGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [AW-1:0]                rd_addr,
  input  logic                         snap_req,
  input  logic [TIME_REGS*BYTE_W-1:0]  time_live_i,
  input  logic [1:0]                   alarm_set_i,
  output logic [BYTE_W-1:0]            rd_data,
  output logic                         time_wr_o,
  output logic [TW-1:0]                time_wr_idx_o,
  output logic [BYTE_W-1:0]            time_wr_data_o,
  output logic [BYTE_W-1:0]            ctrl_o,
  output logic [ALARM_REGS*BYTE_W-1:0] alarm_o,
  output logic [1:0]                   flags_o
);
  localparam int ALARM_BASE = TIME_REGS;
  localparam int CTRL_ADDR  = ALARM_BASE + ALARM_REGS;
  localparam int STAT_ADDR  = CTRL_ADDR + 1;
  localparam int SRAM_BASE  = STAT_ADDR + 1;
  localparam int NSRAM      = (1 << AW) - SRAM_BASE;

  logic [BYTE_W-1:0] snap_q  [TIME_REGS];
  logic [BYTE_W-1:0] alarm_q [ALARM_REGS];
  logic [BYTE_W-1:0] sram_q  [NSRAM];
  logic [BYTE_W-1:0] ctrl_q;
  logic [1:0]        flag_q;
  logic              stat_wr;

  assign stat_wr = wr_en && (wr_addr == AW'(STAT_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TIME_REGS; i++)  snap_q[i]  <= '0;
      for (int i = 0; i < ALARM_REGS; i++) alarm_q[i] <= '0;
      for (int i = 0; i < NSRAM; i++)      sram_q[i]  <= '0;
      ctrl_q <= CTRL_RST;
      flag_q <= '0;
    end else begin
      if (snap_req)
        for (int i = 0; i < TIME_REGS; i++) snap_q[i] <= time_live_i[BYTE_W*i +: BYTE_W];
      if (wr_en) begin
        for (int i = 0; i < ALARM_REGS; i++)
          if (wr_addr == AW'(ALARM_BASE + i)) alarm_q[i] <= wr_data;
        for (int i = 0; i < NSRAM; i++)
          if (wr_addr == AW'(SRAM_BASE + i)) sram_q[i] <= wr_data;
        if (wr_addr == AW'(CTRL_ADDR)) ctrl_q <= wr_data;
      end
      // a set pulse wins over a clearing write in the same cycle
      for (int b = 0; b < 2; b++) begin
        if (alarm_set_i[b])              flag_q[b] <= 1'b1;
        else if (stat_wr && !wr_data[b]) flag_q[b] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < TIME_REGS; i++)
      if (rd_addr == AW'(i)) rd_data = snap_q[i];
    for (int i = 0; i < ALARM_REGS; i++)
      if (rd_addr == AW'(ALARM_BASE + i)) rd_data = alarm_q[i];
    for (int i = 0; i < NSRAM; i++)
      if (rd_addr == AW'(SRAM_BASE + i)) rd_data = sram_q[i];
    if (rd_addr == AW'(CTRL_ADDR)) rd_data = ctrl_q;
    if (rd_addr == AW'(STAT_ADDR)) rd_data = {6'b0, flag_q};
  end

  assign time_wr_o      = wr_en && (wr_addr < AW'(TIME_REGS));
  assign time_wr_idx_o  = wr_addr[TW-1:0];
  assign time_wr_data_o = wr_data;
  assign ctrl_o         = ctrl_q;
  assign flags_o        = flag_q;

  for (genvar g = 0; g < ALARM_REGS; g++) begin : g_alarm_out
    assign alarm_o[BYTE_W*g +: BYTE_W] = alarm_q[g];
  end
endmodule

// File: rtl/rtc_i2c_regfile.sv
`timescale 1ns/1ps
module rtc_i2c_regfile #(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         AW          = 5,
  parameter int         TIME_REGS   = 7,
  parameter int         ALARM_REGS  = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CTRL_RST    = 8'h98
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe_o,
  input  logic [TIME_REGS*8-1:0]      time_live_i,
  output logic                        time_wr_o,
  output logic [$clog2(TIME_REGS)-1:0] time_wr_idx_o,
  output logic [7:0]                  time_wr_data_o,
  input  logic [1:0]                  alarm_set_i,
  output logic [7:0]                  ctrl_o,
  output logic [ALARM_REGS*8-1:0]     alarm_o,
  output logic [1:0]                  flags_o
);
  logic          sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    rd_data, wr_data;
  logic [AW-1:0] ptr, wr_addr;
  logic          wr_en, snap_req;

  i2c_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe_o), .ptr(ptr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .snap_req(snap_req)
  );

  rtc_reg_bank #(
    .AW(AW), .TIME_REGS(TIME_REGS), .ALARM_REGS(ALARM_REGS), .CTRL_RST(CTRL_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .snap_req(snap_req),
    .time_live_i(time_live_i), .alarm_set_i(alarm_set_i), .rd_data(rd_data),
    .time_wr_o(time_wr_o), .time_wr_idx_o(time_wr_idx_o),
    .time_wr_data_o(time_wr_data_o), .ctrl_o(ctrl_o), .alarm_o(alarm_o),
    .flags_o(flags_o)
  );
endmodule

// File: rtl/rtc_i2c_regfile_chk.sv
`timescale 1ns/1ps
module rtc_i2c_regfile_chk #(
  parameter int         TIME_REGS = 7,
  parameter logic [7:0] CTRL_RST  = 8'h98
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         scl_i,
  input logic                         sda_oe_o,
  input logic                         time_wr_o,
  input logic [$clog2(TIME_REGS)-1:0] time_wr_idx_o,
  input logic [1:0]                   alarm_set_i,
  input logic [1:0]                   flags_o,
  input logic [7:0]                   ctrl_o
);
  // R10: a time write strobe lasts one cycle
  assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_o |=> !time_wr_o);
  // R10: strobe index stays inside the time bytes
  assert_wr_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_o |-> (int'(time_wr_idx_o) < TIME_REGS));
  // R11: a flag rises only after a set pulse
  assert_flag1_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[0]) |-> $past(alarm_set_i[0]));
  assert_flag2_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[1]) |-> $past(alarm_set_i[1]));
  // R8: the slave starts pulling SDA only while SCL is low
  assert_drive_low_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);
  // R9: control byte holds its reset value when reset ends
  assert_ctrl_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_o == CTRL_RST));
endmodule

bind rtc_i2c_regfile rtc_i2c_regfile_chk #(.TIME_REGS(TIME_REGS), .CTRL_RST(CTRL_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .time_wr_o(time_wr_o), .time_wr_idx_o(time_wr_idx_o),
  .alarm_set_i(alarm_set_i), .flags_o(flags_o), .ctrl_o(ctrl_o)
);

// File: tb/sim_rtc_i2c_regfile.sv
`timescale 1ns/1ps
module sim_rtc_i2c_regfile;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_bus;
  logic        sda_oe;
  logic [55:0] live = '0;
  logic        time_wr;
  logic [2:0]  time_idx;
  logic [7:0]  time_data;
  logic [1:0]  aset = '0;
  logic [7:0]  ctrl;
  logic [55:0] alarms;
  logic [1:0]  flags;

  int n_chk = 0, n_fail = 0, tw_cnt = 0;
  logic [2:0] tw_idx;
  logic [7:0] tw_data;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  rtc_i2c_regfile u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .time_live_i(live), .time_wr_o(time_wr), .time_wr_idx_o(time_idx),
    .time_wr_data_o(time_data), .alarm_set_i(aset), .ctrl_o(ctrl),
    .alarm_o(alarms), .flags_o(flags)
  );

  always @(posedge clk) if (time_wr) begin
    tw_cnt  <= tw_cnt + 1;
    tw_idx  <= time_idx;
    tw_data <= time_data;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; scl_m = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nak);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!give_ack);
  endtask

  task automatic put_reg(input logic [7:0] p, input logic [7:0] d);
    logic k;
    bus_start(); wbyte(8'hD0, k); wbyte(p, k); wbyte(d, k); bus_stop();
  endtask

  task automatic get_reg(input logic [7:0] p, output logic [7:0] d);
    logic k;
    bus_start(); wbyte(8'hD0, k); wbyte(p, k);
    bus_start(); wbyte(8'hD1, k); rbyte(1'b0, d); bus_stop();
  endtask

  task automatic t_reset();
    chk("R9 ctrl reset", ctrl, 8'h98);
    chk("R9 flags reset", flags, 2'b00);
    chk("R9 alarms reset", alarms, 56'h0);
    chk("R9 sda released", sda_oe, 1'b0);
  endtask

  task automatic t_address();
    logic k;
    int c0 = tw_cnt;
    bus_start(); wbyte(8'hA0, k);
    chk("R1 foreign address nack", k, 1'b1);
    wbyte(8'h00, k);
    chk("R1 ignored after nack", k, 1'b1);
    wbyte(8'h55, k);
    bus_stop();
    chk("R1 no write while ignored", tw_cnt, c0);
    bus_start(); wbyte(8'hD0, k);
    chk("R1 own address ack", k, 1'b0);
    bus_stop();
  endtask

  task automatic t_sram_rw();
    logic k;
    logic [7:0] d0, d1, d2;
    bus_start(); wbyte(8'hD0, k); wbyte(8'h12, k);
    wbyte(8'h5A, k); chk("R2 data ack", k, 1'b0);
    wbyte(8'hC3, k); wbyte(8'h81, k); wbyte(8'h7E, k);
    bus_stop();
    bus_start(); wbyte(8'hD0, k); wbyte(8'h12, k);
    bus_start(); wbyte(8'hD1, k);
    chk("R7 read address after repeated start", k, 1'b0);
    rbyte(1'b1, d0); rbyte(1'b1, d1); rbyte(1'b0, d2);
    chk("R2 r7_ byte at 12h", d0, 8'h5A);
    chk("R8 msb first at 13h", d1, 8'hC3);
    chk("R2 increment to 14h", d2, 8'h81);
    chk("R6 released after nack", sda_oe, 1'b0);
    get_bit(k);
    chk("R6 bus stays high after nack", k, 1'b1);
    bus_stop();
    bus_start(); wbyte(8'hD1, k); rbyte(1'b0, d0); bus_stop();
    chk("R5 read continues at 15h", d0, 8'h7E);
  endtask

  task automatic t_wrap_time();
    logic k;
    logic [7:0] d;
    int c0 = tw_cnt;
    bus_start(); wbyte(8'hD0, k); wbyte(8'h1F, k);
    wbyte(8'hAA, k); wbyte(8'hBB, k); bus_stop();
    chk("R3 second byte lands at 00h", tw_idx, 3'd0);
    chk("R3 wrapped data", tw_data, 8'hBB);
    get_reg(8'h1F, d);
    chk("R3 byte at 1Fh", d, 8'hAA);
    bus_start(); wbyte(8'hD0, k); wbyte(8'h03, k);
    wbyte(8'h11, k); wbyte(8'h22, k); bus_stop();
    chk("R10 strobe count", tw_cnt - c0, 3);
    chk("R10 strobe index", tw_idx, 3'd4);
    chk("R10 strobe data", tw_data, 8'h22);
  endtask

  task automatic t_snapshot();
    logic k;
    logic [7:0] d0, d1, d2;
    live = 56'h16151413121110;
    put_reg(8'h0E, 8'h98);
    bus_start(); wbyte(8'hD0, k); wbyte(8'h00, k); bus_stop();
    bus_start(); wbyte(8'hD1, k);
    rbyte(1'b1, d0);
    live = 56'h26252423222120;
    rbyte(1'b1, d1); rbyte(1'b0, d2); bus_stop();
    chk("R4 byte0 from snapshot", d0, 8'h10);
    chk("R4 frozen mid read", d1, 8'h11);
    chk("R4 frozen byte2", d2, 8'h12);
    get_reg(8'h00, d0);
    chk("R4 refreshed at start", d0, 8'h20);
    bus_start(); wbyte(8'hD0, k); wbyte(8'h1F, k); bus_stop();
    live = 56'h36353433323130;
    bus_start(); wbyte(8'hD1, k);
    live = 56'h46454443424140;
    rbyte(1'b1, d0); rbyte(1'b0, d1); bus_stop();
    chk("R5 read from stored pointer 1Fh", d0, 8'hAA);
    chk("R4 refreshed at wrap", d1, 8'h40);
  endtask

  task automatic t_ctrl_alarm();
    logic k;
    logic [7:0] d;
    put_reg(8'h0E, 8'h45);
    chk("R12 ctrl out", ctrl, 8'h45);
    bus_start(); wbyte(8'hD0, k); wbyte(8'h07, k);
    for (int i = 1; i <= 7; i++) wbyte(8'(i * 8'h11), k);
    bus_stop();
    chk("R12 alarm out", alarms, 56'h77665544332211);
    get_reg(8'h0E, d);
    chk("R12 ctrl readback", d, 8'h45);
    get_reg(8'h0A, d);
    chk("R12 alarm readback", d, 8'h44);
  endtask

  task automatic t_status();
    logic [7:0] d;
    @(posedge clk); #1 aset = 2'b11;
    @(posedge clk); #1 aset = 2'b00;
    @(posedge clk); #1;
    chk("R11 flags set", flags, 2'b11);
    get_reg(8'h0F, d);
    chk("R11 status read, upper zero", d, 8'h03);
    put_reg(8'h0F, 8'hFF);
    chk("R11 writing ones keeps flags", flags, 2'b11);
    put_reg(8'h0F, 8'hFE);
    chk("R11 clear flag1", flags, 2'b10);
    get_reg(8'h0F, d);
    chk("R11 status after clear", d, 8'h02);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wq();
    t_reset();
    t_address();
    t_sram_rw();
    t_wrap_time();
    t_snapshot();
    t_ctrl_alarm();
    t_status();
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule